// File: doc/BRIEF.md
# Dual-Rail Tower-Field AES S-Box

This block applies the forward AES byte substitution to one byte carried in dual-rail form. Every logical bit travels on a pair of wires. A pair with neither wire high is a spacer (NULL). A pair with exactly one wire high is a valid bit. Words alternate with spacers, so a word is presented, then NULL, then the next word. The substitution is computed arithmetically, not from a stored table. The byte is mapped into a tower-field basis GF(((2^2)^2)^2), where it is inverted with three GF(2^4) multipliers, GF(2^4) squaring, a constant multiplier and XOR addition. The result is then mapped back to the polynomial basis and passed through the AES affine transform.

The output pairs sit in a wavefront register that follows the rules of self-timed threshold logic. The register captures a new word only once every input pair is valid and the previous word has been cleared. It falls back to NULL only once every input pair is NULL. A completion flag follows the register contents, much as a C-element does. The tower polynomial constants are parameters. The change-of-basis matrices are derived from them during elaboration.

Top module: `dr_sbox`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, every output pair is NULL and `done` is 0.
- R2: Bit i of a word sits on wires [2i+1:2i], so the pair for bit 7 is at the top. On that pair, `10` means logic 1, `01` means logic 0 and `00` means NULL. For example, the result 0x7C appears as `0110101010100101`.
- R3: For every input byte b in 0x00..0xFF, the output word is the AES forward S-box value of b. Examples: 0x01 gives 0x7C, 0x85 gives 0x97, 0x00 gives 0x63.
- R4: Output pairs leave NULL only after all eight input pairs hold valid bits. If any input pair is still NULL, the output stays NULL.
- R5: Output pairs return to NULL only after all eight input pairs are NULL. If any input pair still holds a bit, the previous word stays on the output.
- R6: No output pair ever shows `11`.
- R7: `done` goes to 1 one cycle after the output holds a full word. It goes to 0 one cycle after the output is all NULL. Otherwise it keeps its value.
- R8: An input pair at `11` counts as neither valid nor NULL, so the output keeps whatever it holds.
- R9: When the last input pair becomes valid, the output word appears after exactly one rising clock edge.
- R10: A new valid word that arrives with no NULL spacer between it and the previous word is ignored, and the output keeps the earlier result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the wavefront register and completion flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Input byte as eight dual-rail pairs |
| dout | output | 16 | Substituted byte as eight dual-rail pairs |
| done | output | 1 | Completion flag: 1 after a full word, 0 after a full spacer |

## Verification
The bench checks the whole byte space against a table that it builds itself. The table uses plain polynomial-basis inversion, so any error in the basis change or the tower arithmetic shows up as wrong bytes. This is most visible at 0x00 and in values that exercise the high nibble. Partial wavefronts are also covered. One missing pair on the way up, one lingering pair on the way down, and a `11` pair must each freeze the output. A register that loaded on any valid pair would publish a premature, wrong word, and one that cleared on any NULL pair would lose its result early. A word presented without a spacer must be ignored, otherwise the output would switch words with no NULL in between. The bench also samples `done` on the cycle before and the cycle after each change, which exposes a flag that tracks the input instead of the output or lags by the wrong number of edges.

// File: rtl/dr_sbox_pkg.sv
package dr_sbox_pkg;

   localparam int BYTE_W = 8;
   localparam int RAIL_W = 2 * BYTE_W;

   typedef logic [7:0]      byte_t;
   typedef logic [3:0]      nib_t;
   typedef logic [1:0]      duo_t;
   typedef logic [7:0][7:0] mat8_t;   // column i is the image of basis bit i

   localparam duo_t PAIR_NULL = 2'b00;
   localparam duo_t PAIR_ONE  = 2'b10;
   localparam duo_t PAIR_ZERO = 2'b01;

   // GF(2^2) with w^2 = w + 1
   function automatic duo_t gf4_mul(duo_t a, duo_t b);
      duo_t r;
      r[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
      r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
      return r;
   endfunction

   // GF((2^2)^2) with y^2 = y + phi
   function automatic nib_t gf16_mul(nib_t a, nib_t b, duo_t phi);
      duo_t hh;
      hh = gf4_mul(a[3:2], b[3:2]);
      return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
              gf4_mul(hh, phi) ^ gf4_mul(a[1:0], b[1:0])};
   endfunction

   function automatic nib_t gf16_inv(nib_t a, duo_t phi);
      duo_t dl, di;
      dl = gf4_mul(gf4_mul(a[3:2], a[3:2]), phi)
         ^ gf4_mul(a[3:2], a[1:0]) ^ gf4_mul(a[1:0], a[1:0]);
      di = gf4_mul(dl, dl);              // in GF(4) the inverse is the square
      return {gf4_mul(a[3:2], di), gf4_mul(a[3:2] ^ a[1:0], di)};
   endfunction

   // GF(((2^2)^2)^2) with z^2 = z + lambda
   function automatic byte_t gf256_mul(byte_t a, byte_t b, duo_t phi, nib_t lam);
      nib_t hh;
      hh = gf16_mul(a[7:4], b[7:4], phi);
      return {hh ^ gf16_mul(a[7:4], b[3:0], phi) ^ gf16_mul(a[3:0], b[7:4], phi),
              gf16_mul(hh, lam, phi) ^ gf16_mul(a[3:0], b[3:0], phi)};
   endfunction

   function automatic bit phi_is_irreducible(duo_t phi);
      for (int w = 0; w < 4; w++) begin
         if ((gf4_mul(w[1:0], w[1:0]) ^ w[1:0]) == phi) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic bit lam_is_irreducible(nib_t lam, duo_t phi);
      for (int z = 0; z < 16; z++) begin
         if ((gf16_mul(z[3:0], z[3:0], phi) ^ z[3:0]) == lam) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic nib_t pick_lambda(duo_t phi);
      for (int c = 1; c < 16; c++) begin
         if (lam_is_irreducible(c[3:0], phi)) return c[3:0];
      end
      return 4'h0;
   endfunction

   // element of the tower field that is a root of x^8+x^4+x^3+x+1
   function automatic byte_t find_root(duo_t phi, nib_t lam);
      byte_t x, x2, x3, x4, x8;
      for (int c = 2; c < 256; c++) begin
         x  = c[7:0];
         x2 = gf256_mul(x, x, phi, lam);
         x3 = gf256_mul(x2, x, phi, lam);
         x4 = gf256_mul(x2, x2, phi, lam);
         x8 = gf256_mul(x4, x4, phi, lam);
         if ((x8 ^ x4 ^ x3 ^ x ^ 8'h01) == 8'h00) return x;
      end
      return 8'h00;
   endfunction

   function automatic byte_t mat_apply(mat8_t m, byte_t v);
      byte_t r;
      r = '0;
      for (int i = 0; i < 8; i++) begin
         if (v[i]) r = r ^ m[i];
      end
      return r;
   endfunction

   function automatic mat8_t build_fwd_map(duo_t phi, nib_t lam);
      mat8_t m;
      byte_t beta, p;
      beta = find_root(phi, lam);
      p    = 8'h01;
      for (int i = 0; i < 8; i++) begin
         m[i] = p;
         p    = gf256_mul(p, beta, phi, lam);
      end
      return m;
   endfunction

   function automatic mat8_t build_bwd_map(mat8_t fwd);
      mat8_t m;
      m = '0;
      for (int j = 0; j < 8; j++) begin
         for (int b = 0; b < 256; b++) begin
            if (mat_apply(fwd, b[7:0]) == (8'h01 << j)) m[j] = b[7:0];
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/dr_rail_decode.sv
module dr_rail_decode #(
   parameter int NBITS = 8
) (
   input  logic [2*NBITS-1:0] rails,
   output logic [NBITS-1:0]   value,
   output logic               all_data,
   output logic               all_null
);
   logic [NBITS-1:0] is_data;
   logic [NBITS-1:0] is_null;

   for (genvar i = 0; i < NBITS; i++) begin : g_pair
      assign value[i]   = rails[2*i+1];
      assign is_data[i] = rails[2*i+1] ^ rails[2*i];
      assign is_null[i] = ~(rails[2*i+1] | rails[2*i]);
   end

   assign all_data = &is_data;
   assign all_null = &is_null;
endmodule

// File: rtl/tf_inverse.sv
module tf_inverse
   import dr_sbox_pkg::*;
#(
   parameter duo_t PHI = 2'b10,
   parameter nib_t LAM = 4'h1
) (
   input  byte_t a_in,
   output byte_t a_out
);
   nib_t hi, lo, hi_sq, lo_sq, hi_lo, delta, delta_inv;

   assign hi        = a_in[7:4];
   assign lo        = a_in[3:0];
   assign hi_sq     = gf16_mul(hi, hi, PHI);                 // squarer
   assign lo_sq     = gf16_mul(lo, lo, PHI);                 // squarer
   assign hi_lo     = gf16_mul(hi, lo, PHI);                 // multiplier 1
   assign delta     = gf16_mul(hi_sq, LAM, PHI) ^ hi_lo ^ lo_sq;
   assign delta_inv = gf16_inv(delta, PHI);
   assign a_out     = {gf16_mul(hi, delta_inv, PHI),         // multiplier 2
                       gf16_mul(hi ^ lo, delta_inv, PHI)};   // multiplier 3
endmodule

// File: rtl/tf_sbox_core.sv
module tf_sbox_core
   import dr_sbox_pkg::*;
#(
   parameter duo_t  PHI      = 2'b10,
   parameter nib_t  LAM      = 4'h1,
   parameter mat8_t MAP_FWD  = '0,
   parameter mat8_t MAP_BWD  = '0,
   parameter byte_t AFFINE_C = 8'h63
) (
   input  byte_t b_in,
   output byte_t s_out
);
   byte_t tower_in, tower_inv, poly_inv;

   assign tower_in = mat_apply(MAP_FWD, b_in);

   tf_inverse #(.PHI(PHI), .LAM(LAM)) u_inv (
      .a_in  (tower_in),
      .a_out (tower_inv)
   );

   assign poly_inv = mat_apply(MAP_BWD, tower_inv);

   for (genvar i = 0; i < BYTE_W; i++) begin : g_affine
      assign s_out[i] = poly_inv[i]
                      ^ poly_inv[(i + 4) % BYTE_W] ^ poly_inv[(i + 5) % BYTE_W]
                      ^ poly_inv[(i + 6) % BYTE_W] ^ poly_inv[(i + 7) % BYTE_W]
                      ^ AFFINE_C[i];
   end
endmodule

// File: rtl/dr_wave_reg.sv
module dr_wave_reg #(
   parameter int NBITS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NBITS-1:0]   value,
   input  logic               in_all_data,
   input  logic               in_all_null,
   output logic [2*NBITS-1:0] pairs,
   output logic               done
);
   logic [2*NBITS-1:0] pairs_d;
   logic [2*NBITS-1:0] pairs_q;
   logic [NBITS-1:0]   q_data, q_null;
   logic               out_all_data, out_all_null;

   for (genvar i = 0; i < NBITS; i++) begin : g_pair
      assign pairs_d[2*i+1 -: 2] = {value[i], ~value[i]};
      assign q_data[i] = pairs_q[2*i+1] ^ pairs_q[2*i];
      assign q_null[i] = ~(pairs_q[2*i+1] | pairs_q[2*i]);
   end

   assign out_all_data = &q_data;
   assign out_all_null = &q_null;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pairs_q <= '0;
         done    <= 1'b0;
      end else begin
         if (in_all_data && out_all_null) pairs_q <= pairs_d;
         else if (in_all_null)            pairs_q <= '0;
         if (out_all_data)      done <= 1'b1;
         else if (out_all_null) done <= 1'b0;
      end
   end

   assign pairs = pairs_q;
endmodule

// File: rtl/dr_sbox.sv
module dr_sbox #(
   parameter dr_sbox_pkg::duo_t  PHI      = 2'b10,
   parameter dr_sbox_pkg::nib_t  LAMBDA   = 4'h0,   // 0 selects the first irreducible value
   parameter dr_sbox_pkg::byte_t AFFINE_C = 8'h63
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [dr_sbox_pkg::RAIL_W-1:0] din,
   output logic [dr_sbox_pkg::RAIL_W-1:0] dout,
   output logic                           done
);
   import dr_sbox_pkg::*;

   localparam nib_t  LAM_EFF = (LAMBDA == 4'h0) ? pick_lambda(PHI) : LAMBDA;
   localparam byte_t ROOT    = find_root(PHI, LAM_EFF);
   localparam mat8_t MAP_FWD = build_fwd_map(PHI, LAM_EFF);
   localparam mat8_t MAP_BWD = build_bwd_map(MAP_FWD);

   if (!phi_is_irreducible(PHI)) begin : g_bad_phi
      $error("dr_sbox: PHI does not give an irreducible GF(2^4) polynomial");
   end
   if (!lam_is_irreducible(LAM_EFF, PHI)) begin : g_bad_lambda
      $error("dr_sbox: LAMBDA does not give an irreducible GF(2^8) polynomial");
   end
   if (ROOT == 8'h00) begin : g_no_root
      $error("dr_sbox: no tower element satisfies the AES field polynomial");
   end

   byte_t in_value, sub_value;
   logic  in_all_data, in_all_null;

   dr_rail_decode #(.NBITS(BYTE_W)) u_dec (
      .rails    (din),
      .value    (in_value),
      .all_data (in_all_data),
      .all_null (in_all_null)
   );

   tf_sbox_core #(
      .PHI      (PHI),
      .LAM      (LAM_EFF),
      .MAP_FWD  (MAP_FWD),
      .MAP_BWD  (MAP_BWD),
      .AFFINE_C (AFFINE_C)
   ) u_core (
      .b_in  (in_value),
      .s_out (sub_value)
   );

   dr_wave_reg #(.NBITS(BYTE_W)) u_wave (
      .clk         (clk),
      .rst_n       (rst_n),
      .value       (sub_value),
      .in_all_data (in_all_data),
      .in_all_null (in_all_null),
      .pairs       (dout),
      .done        (done)
   );
endmodule

// File: rtl/dr_sbox_chk.sv
module dr_sbox_chk #(
   parameter int NBITS = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2*NBITS-1:0] din,
   input logic [2*NBITS-1:0] dout,
   input logic               done
);
   logic in_all_data, in_all_null, out_all_data, out_all_null, out_any_bad;

   always_comb begin
      in_all_data  = 1'b1;
      in_all_null  = 1'b1;
      out_all_data = 1'b1;
      out_all_null = 1'b1;
      out_any_bad  = 1'b0;
      for (int i = 0; i < NBITS; i++) begin
         in_all_data  = in_all_data  & (din[2*i+1] ^ din[2*i]);
         in_all_null  = in_all_null  & ~(din[2*i+1] | din[2*i]);
         out_all_data = out_all_data & (dout[2*i+1] ^ dout[2*i]);
         out_all_null = out_all_null & ~(dout[2*i+1] | dout[2*i]);
         out_any_bad  = out_any_bad  | (dout[2*i+1] & dout[2*i]);
      end
   end

   p_no_illegal_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_any_bad);

   p_rise_needs_full_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_all_data && $past(out_all_null)) |-> $past(in_all_data));

   p_fall_needs_full_spacer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_all_null && $past(out_all_data)) |-> $past(in_all_null));

   p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(out_all_data));

   p_done_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(out_all_null));

   p_hold_on_mixed_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_all_data && !in_all_null) |=> $stable(dout));

   p_no_word_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_all_data && $past(out_all_data)) |-> $stable(dout));
endmodule

bind dr_sbox dr_sbox_chk #(.NBITS(dr_sbox_pkg::BYTE_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .din   (din),
   .dout  (dout),
   .done  (done)
);

// File: tb/sim_dr_sbox.sv
module sim_dr_sbox;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] din = '0;
   logic [15:0] dout;
   logic        done;
   int          n_chk = 0;
   int          n_fail = 0;
   logic [7:0]  ref_tab [256];

   always #4 clk = ~clk;   // 125 MHz

   dr_sbox u0 (.clk(clk), .rst_n(rst_n), .din(din), .dout(dout), .done(done));

   function automatic logic [7:0] pmul(logic [7:0] a, logic [7:0] b);
      logic [7:0] r = '0;
      logic [7:0] x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r = r ^ x;
         x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
      end
      return r;
   endfunction

   function automatic logic [7:0] rotl(logic [7:0] v, int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   function automatic logic [15:0] enc(logic [7:0] b);
      logic [15:0] w;
      for (int i = 0; i < 8; i++) w[2*i+1 -: 2] = b[i] ? 2'b10 : 2'b01;
      return w;
   endfunction

   function automatic bit has_bad_pair(logic [15:0] w);
      for (int i = 0; i < 8; i++) if (w[2*i+1 -: 2] == 2'b11) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_out(input string req, input logic [15:0] exp);
      chk(dout === exp, req, dout, exp);
   endtask

   task automatic chk_done(input string req, input logic exp);
      chk(done === exp, req, {15'd0, done}, {15'd0, exp});
   endtask

   task automatic put(input logic [15:0] w);   // drive, then wait one edge
      @(negedge clk);
      din = w;
      @(negedge clk);
   endtask

   task automatic clear_all();
      put('0);
      @(negedge clk);
   endtask

   task automatic t_reset();
      din = enc(8'h85);
      repeat (3) @(negedge clk);
      chk_out("R1 outputs NULL in reset", '0);
      chk_done("R1 done low in reset", 1'b0);
      din = '0;
      rst_n = 1'b1;
      @(negedge clk);
      chk_out("R1 outputs NULL after release", '0);
      chk_done("R1 done low after release", 1'b0);
   endtask

   task automatic t_known_words();
      put(enc(8'h01));
      chk_out("R2 encoding of 0x7C", 16'b0110101010100101);
      clear_all();
      put(enc(8'h85));
      chk_out("R3 0x85 gives 0x97", enc(8'h97));
      clear_all();
      put(enc(8'h00));
      chk_out("R3 0x00 gives 0x63", enc(8'h63));
      clear_all();
   endtask

   task automatic t_latency_done();
      @(negedge clk);
      din = enc(8'h53);
      @(negedge clk);
      chk_out("R9 word after one edge", enc(ref_tab[8'h53]));
      chk_done("R7 done still low one edge after input", 1'b0);
      @(negedge clk);
      chk_done("R7 done high after full word", 1'b1);
      din = '0;
      @(negedge clk);
      chk_out("R9 NULL after one edge", '0);
      chk_done("R7 done holds while output clears", 1'b1);
      @(negedge clk);
      chk_done("R7 done low after full spacer", 1'b0);
   endtask

   task automatic t_sweep();
      for (int b = 0; b < 256; b++) begin
         put(enc(b[7:0]));
         chk_out("R3 sweep value", enc(ref_tab[b]));
         chk(!has_bad_pair(dout), "R6 no 11 pair", dout, enc(ref_tab[b]));
         @(negedge clk);
         chk_done("R7 done per word", 1'b1);
         put('0);
         chk_out("R5 spacer clears", '0);
         @(negedge clk);
         chk_done("R7 done per spacer", 1'b0);
      end
   endtask

   task automatic t_partial_rise();
      logic [15:0] w = enc(8'h85);
      w[7:6] = 2'b00;
      put(w);
      @(negedge clk);
      chk_out("R4 one NULL pair keeps output NULL", '0);
      chk_done("R4 done stays low", 1'b0);
      put(enc(8'h85));
      chk_out("R4 word appears once complete", enc(8'h97));
      @(negedge clk);
   endtask

   task automatic t_partial_fall();
      logic [15:0] w = '0;
      w[11:10] = 2'b10;
      put(w);
      @(negedge clk);
      chk_out("R5 lingering pair keeps word", enc(8'h97));
      chk_done("R5 done stays high", 1'b1);
      clear_all();
      chk_out("R5 full spacer clears", '0);
   endtask

   task automatic t_illegal();
      logic [15:0] w = enc(8'h38);
      w[1:0] = 2'b11;
      put(w);
      @(negedge clk);
      chk_out("R8 11 pair does not release NULL", '0);
      put(enc(8'h38));
      chk_out("R8 legal word after 11 pair", enc(ref_tab[8'h38]));
      put(w);
      @(negedge clk);
      chk_out("R8 11 pair does not clear word", enc(ref_tab[8'h38]));
      clear_all();
   endtask

   task automatic t_no_spacer();
      put(enc(8'h10));
      @(negedge clk);
      put(enc(8'h20));
      @(negedge clk);
      chk_out("R10 word without spacer ignored", enc(ref_tab[8'h10]));
      chk_done("R10 done stays high", 1'b1);
      clear_all();
      put(enc(8'h20));
      chk_out("R10 word accepted after spacer", enc(ref_tab[8'h20]));
      clear_all();
   endtask

   initial begin
      for (int b = 0; b < 256; b++) begin
         logic [7:0] inv = 8'h00;
         for (int y = 1; y < 256; y++) if (pmul(b[7:0], y[7:0]) == 8'h01) inv = y[7:0];
         ref_tab[b] = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
      end
      t_reset();
      t_known_words();
      t_latency_done();
      t_partial_rise();
      t_partial_fall();
      t_illegal();
      t_no_spacer();
      t_sweep();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule